// File: doc/BRIEF.md
# Repeat-Area Offset Address Generator for a DMA Channel

This block produces the source and destination addresses for one DMA channel, one address pair per granted beat. On the source side the address can advance by a programmable unsigned offset rather than by the access size, inside a repeat area of a programmed byte length. When a repeat area has been covered, the source address jumps back to the start of the area. The channel then raises an interrupt and switches itself off. The destination side steps by the access size (up, down or not at all) and runs on across repeat areas without interruption.

A typical use is transposing a matrix. The offset is set to one row pitch and the repeat size to one column's worth of bytes. After each interrupt, software writes the next column's start address, clears the interrupt and sets the enable bit again. The channel then continues from the state it held when it stopped. An optional total beat count ends the channel permanently and raises a separate completion flag.

Top module: `dma_rpt_addrgen`

## Requirements
- R1: During and after a synchronous reset (`rst` high), the following are all zero: `src_addr`, `dst_addr`, `xfer_size`, `xfer_gnt`, `rpt_irq` and `done_flag`. The channel is disabled after reset.
- R2: Register writes use word index `cfg_addr`:
  - 0 is the source address and 1 is the destination address.
  - 2 is the offset and 3 is the repeat size in bytes.
  - 4 is control: bits 1:0 are the size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), bits 3:2 are the destination mode, bit 4 enables offset stepping and bit 8 is the enable.
  - 5 is write-one-to-clear status: bit 0 clears the repeat flag and bit 1 clears the completion flag.
  - 6 is the total beat count.

  `xfer_gnt` equals `xfer_req` while the channel is enabled. A granted beat uses the `src_addr` and `dst_addr` shown in that cycle. `xfer_size` shows the size code.
- R3: After a granted beat that does not end a repeat area, `src_addr` grows by the offset when offset stepping is on, and by the access size in bytes when it is off.
- R4: After each granted beat, `dst_addr` changes by the destination mode: mode 0 holds it, mode 1 adds the access size and mode 2 subtracts it.
- R5: With a nonzero repeat size, consider the beat on which the bytes moved since the repeat start reach the repeat size. That beat returns `src_addr` to the repeat start address, sets `rpt_irq` and disables the channel.
- R6: A repeat size of zero never ends a repeat area.
- R7: Writing the source address sets both the current source address and the repeat start address, and clears the repeat progress.
- R8: Setting the enable bit again after a repeat end resumes from the held state. The destination address continues on from where it stopped.
- R9: `rpt_irq` stays set until a status write with bit 0 set. A status write with bit 0 clear leaves it set.
- R10: While the channel is disabled, `xfer_req` is not granted and both addresses hold.
- R11: A nonzero total count decrements on each granted beat. When it reaches zero, `done_flag` is set and the channel is disabled. While `done_flag` is set, writes to the enable bit are ignored. Status bit 1 clears `done_flag`. A count of zero means the count is not used.
- R12: If a single beat both empties the total count and ends a repeat area, `done_flag` is set and `rpt_irq` is not.
- R13: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| xfer_req | input | 1 | Transfer request for one beat |
| xfer_gnt | output | 1 | Beat accepted this cycle |
| src_addr | output | 32 | Source address of the current beat |
| dst_addr | output | 32 | Destination address of the current beat |
| xfer_size | output | 2 | Access size code of the beat |
| rpt_irq | output | 1 | Repeat-area end interrupt, sticky |
| done_flag | output | 1 | Total count exhausted, sticky |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a 16-bit repeat size and count. With these values a full 4x4 longword transpose fits, with a 16-byte offset and a 16-byte repeat area, and the bench checks the sixteen source and destination addresses of that transpose beat by beat. The 32-bit width also puts the modulo-2^32 wrap within reach from a start address just below the top of the address space. The narrow repeat field still allows small repeat areas of 8 bytes, where software rewrites the source address in the middle of an area and where the count and the repeat end fall on the same beat.

// File: rtl/dma_rpt_pkg.sv
package dma_rpt_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_SRC  = 3'd0;
    localparam logic [REG_AW-1:0] REG_DST  = 3'd1;
    localparam logic [REG_AW-1:0] REG_OFS  = 3'd2;
    localparam logic [REG_AW-1:0] REG_RPT  = 3'd3;
    localparam logic [REG_AW-1:0] REG_CTRL = 3'd4;
    localparam logic [REG_AW-1:0] REG_STAT = 3'd5;
    localparam logic [REG_AW-1:0] REG_CNT  = 3'd6;

    localparam int CTRL_EN_BIT  = 8;
    localparam int CTRL_OFS_BIT = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } xsize_e;

    typedef enum logic [1:0] {
        DM_FIXED = 2'd0,
        DM_INC   = 2'd1,
        DM_DEC   = 2'd2
    } dmode_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_rpt_regs.sv
module dma_rpt_regs
    import dma_rpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [AW-1:0]     wdata,
    input  logic              fire,
    input  logic              rpt_hit,
    output logic              en,
    output logic [1:0]        size,
    output logic [1:0]        dmode,
    output logic              ofs_en,
    output logic [AW-1:0]     offset,
    output logic [CW-1:0]     rpt_size,
    output logic              src_load,
    output logic              dst_load,
    output logic              irq,
    output logic              done
);

    logic [CW-1:0] cnt_left;
    logic          cnt_on;
    logic          last_beat;

    assign last_beat = cnt_on && (cnt_left == CW'(1));
    assign src_load  = we && (waddr == REG_SRC);
    assign dst_load  = we && (waddr == REG_DST);

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            size     <= 2'd0;
            dmode    <= 2'd0;
            ofs_en   <= 1'b0;
            offset   <= '0;
            rpt_size <= '0;
            cnt_left <= '0;
            cnt_on   <= 1'b0;
            irq      <= 1'b0;
            done     <= 1'b0;
        end else begin
            if (fire) begin
                if (cnt_on) begin
                    cnt_left <= cnt_left - CW'(1);
                    if (last_beat) begin
                        cnt_on <= 1'b0;
                        done   <= 1'b1;
                        en     <= 1'b0;
                    end
                end
                if (rpt_hit && !last_beat) begin
                    irq <= 1'b1;
                    en  <= 1'b0;
                end
            end
            if (we) begin
                case (waddr)
                    REG_OFS: offset   <= wdata;
                    REG_RPT: rpt_size <= wdata[CW-1:0];
                    REG_CNT: begin
                        cnt_left <= wdata[CW-1:0];
                        cnt_on   <= (wdata[CW-1:0] != '0);
                    end
                    REG_CTRL: begin
                        size   <= wdata[1:0];
                        dmode  <= wdata[3:2];
                        ofs_en <= wdata[CTRL_OFS_BIT];
                        en     <= wdata[CTRL_EN_BIT] && !done;
                    end
                    REG_STAT: begin
                        if (wdata[0]) irq  <= 1'b0;
                        if (wdata[1]) done <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r11_count_needs_on: assert property (@(posedge clk) disable iff (rst)
        fire && last_beat && !we |=> done && !en);

endmodule

// File: rtl/dma_rpt_src.sv
module dma_rpt_src
    import dma_rpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_data,
    input  logic          fire,
    input  logic [1:0]    size,
    input  logic          ofs_en,
    input  logic [AW-1:0] offset,
    input  logic [CW-1:0] rpt_size,
    output logic          rpt_hit,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] start
);

    localparam int PW = CW + 1;

    logic [PW-1:0] prog;
    logic [PW-1:0] prog_nx;
    logic [2:0]    sb;
    logic [AW-1:0] step;

    assign sb      = size_bytes(size);
    assign prog_nx = prog + PW'(sb);
    assign rpt_hit = (rpt_size != '0) && (prog_nx >= PW'(rpt_size));
    assign step    = ofs_en ? offset : AW'(sb);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            start <= '0;
            prog  <= '0;
        end else if (load) begin
            cur   <= load_data;
            start <= load_data;
            prog  <= '0;
        end else if (fire) begin
            if (rpt_hit) begin
                cur  <= start;
                prog <= '0;
            end else begin
                cur  <= cur + step;
                prog <= prog_nx;
            end
        end
    end

    a_r7_load_aligns_start: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == start));

endmodule

// File: rtl/dma_rpt_dst.sv
module dma_rpt_dst
    import dma_rpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_data,
    input  logic          fire,
    input  logic [1:0]    size,
    input  logic [1:0]    dmode,
    output logic [AW-1:0] cur
);

    logic [AW-1:0] sb;

    assign sb = AW'(size_bytes(size));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_data;
        end else if (fire) begin
            case (dmode)
                DM_INC:  cur <= cur + sb;
                DM_DEC:  cur <= cur - sb;
                default: cur <= cur;
            endcase
        end
    end

    a_r4_fixed_holds: assert property (@(posedge clk) disable iff (rst)
        fire && !load && (dmode == DM_FIXED) |=> $stable(cur));

endmodule

// File: rtl/dma_rpt_addrgen.sv
module dma_rpt_addrgen
    import dma_rpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              xfer_req,
    output logic              xfer_gnt,
    output logic [AW-1:0]     src_addr,
    output logic [AW-1:0]     dst_addr,
    output logic [1:0]        xfer_size,
    output logic              rpt_irq,
    output logic              done_flag
);

    logic          chan_en;
    logic          fire;
    logic [1:0]    dmode;
    logic          ofs_en;
    logic [AW-1:0] offset;
    logic [CW-1:0] rpt_size;
    logic          src_load;
    logic          dst_load;
    logic          rpt_hit;
    logic [AW-1:0] rpt_start;

    assign fire     = xfer_req && chan_en;
    assign xfer_gnt = fire;

    dma_rpt_regs #(.AW(AW), .CW(CW)) regs_i (
        .clk(clk), .rst(rst),
        .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
        .fire(fire), .rpt_hit(rpt_hit),
        .en(chan_en), .size(xfer_size), .dmode(dmode), .ofs_en(ofs_en),
        .offset(offset), .rpt_size(rpt_size),
        .src_load(src_load), .dst_load(dst_load),
        .irq(rpt_irq), .done(done_flag)
    );

    dma_rpt_src #(.AW(AW), .CW(CW)) src_i (
        .clk(clk), .rst(rst),
        .load(src_load), .load_data(cfg_wdata),
        .fire(fire), .size(xfer_size), .ofs_en(ofs_en),
        .offset(offset), .rpt_size(rpt_size),
        .rpt_hit(rpt_hit), .cur(src_addr), .start(rpt_start)
    );

    dma_rpt_dst #(.AW(AW)) dst_i (
        .clk(clk), .rst(rst),
        .load(dst_load), .load_data(cfg_wdata),
        .fire(fire), .size(xfer_size), .dmode(dmode),
        .cur(dst_addr)
    );

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !xfer_gnt && !cfg_we |=> $stable(src_addr) && $stable(dst_addr));

    a_r5_snap_to_start: assert property (@(posedge clk) disable iff (rst)
        $rose(rpt_irq) |-> (src_addr == rpt_start));

    a_r5_stops_channel: assert property (@(posedge clk) disable iff (rst)
        $rose(rpt_irq) && !$past(cfg_we) |-> !xfer_gnt);

    a_r11_done_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) && !$past(cfg_we) |-> !xfer_gnt);

    a_r12_done_wins: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> !$rose(rpt_irq));

endmodule

// File: tb/dma_rpt_addrgen_tb.sv
module dma_rpt_addrgen_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] EXP_SRC [16] = '{
        32'h1000, 32'h1010, 32'h1020, 32'h1030,
        32'h1004, 32'h1014, 32'h1024, 32'h1034,
        32'h1008, 32'h1018, 32'h1028, 32'h1038,
        32'h100C, 32'h101C, 32'h102C, 32'h103C
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        xfer_req = 1'b0;
    logic        xfer_gnt;
    logic [31:0] src_addr;
    logic [31:0] dst_addr;
    logic [1:0]  xfer_size;
    logic        rpt_irq;
    logic        done_flag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_rpt_addrgen dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .xfer_req(xfer_req), .xfer_gnt(xfer_gnt),
        .src_addr(src_addr), .dst_addr(dst_addr), .xfer_size(xfer_size),
        .rpt_irq(rpt_irq), .done_flag(done_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic beat(input logic exp_gnt, input string tag);
        @(negedge clk);
        xfer_req = 1'b1;
        #1 chk(tag, {31'd0, xfer_gnt}, {31'd0, exp_gnt});
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 src", src_addr, 0);
        chk("R1 dst", dst_addr, 0);
        chk("R1 flags", {27'd0, xfer_size, xfer_gnt, rpt_irq, done_flag}, 0);
        rst = 1'b0;
        @(negedge clk);
        xfer_req = 1'b1;
        #1 chk("R1 disabled after reset", {31'd0, xfer_gnt}, 0);
        xfer_req = 1'b0;

        // Transpose walk: R2 R3 R4 R5 R8 R9 R10
        wr(3'd0, 32'h1000);
        wr(3'd1, 32'h2000);
        wr(3'd2, 32'h10);
        wr(3'd3, 32'h10);
        wr(3'd4, 32'h116);
        for (int k = 0; k < 16; k++) begin
            chk("R3 src before beat", src_addr, EXP_SRC[k]);
            chk("R8 dst contiguous", dst_addr, 32'h2000 + 32'(4*k));
            chk("R2 size code", {30'd0, xfer_size}, 2);
            beat(1'b1, "R2 grant while enabled");
            if (k % 4 == 3) begin
                chk("R5 irq at row end", {31'd0, rpt_irq}, 1);
                chk("R5 snap to start", src_addr, EXP_SRC[k-3]);
                beat(1'b0, "R5 channel stopped");
                chk("R10 src held", src_addr, EXP_SRC[k-3]);
                chk("R10 dst held", dst_addr, 32'h2000 + 32'(4*(k+1)));
                if (k < 15) begin
                    wr(3'd5, 32'h1);
                    chk("R9 cleared by W1C", {31'd0, rpt_irq}, 0);
                    wr(3'd0, 32'h1000 + 32'(4*((k+1)/4)));
                    wr(3'd4, 32'h116);
                end
            end
        end
        chk("R8 dst final", dst_addr, 32'h2040);

        // R9 writing zero does not clear
        wr(3'd5, 32'h0);
        chk("R9 zero write keeps irq", {31'd0, rpt_irq}, 1);
        wr(3'd5, 32'h1);
        chk("R9 clear", {31'd0, rpt_irq}, 0);

        // R3 offset off, byte; R4 decrement; R6 repeat size zero
        wr(3'd4, 32'h008);
        wr(3'd0, 32'h500);
        wr(3'd1, 32'h300);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h108);
        for (int i = 1; i <= 3; i++) begin
            beat(1'b1, "R6 grant");
            chk("R3 src byte step", src_addr, 32'h500 + 32'(i));
            chk("R4 dst decrement", dst_addr, 32'h300 - 32'(i));
        end
        chk("R6 no repeat end", {31'd0, rpt_irq}, 0);

        // R4 fixed, word size
        wr(3'd4, 32'h101);
        beat(1'b1, "R4 grant");
        chk("R3 src word step", src_addr, 32'h505);
        chk("R4 dst fixed", dst_addr, 32'h2FD);

        // R13 wrap
        wr(3'd0, 32'hFFFF_FFF8);
        wr(3'd2, 32'h10);
        wr(3'd4, 32'h116);
        beat(1'b1, "R13 grant");
        chk("R13 src wraps", src_addr, 32'h8);
        chk("R4 dst increment long", dst_addr, 32'h301);

        // R7 source write reloads start and progress
        wr(3'd4, 32'h016);
        wr(3'd3, 32'h8);
        wr(3'd0, 32'h4000);
        wr(3'd4, 32'h116);
        beat(1'b1, "R7 grant");
        chk("R7 first step", src_addr, 32'h4010);
        wr(3'd0, 32'h6000);
        chk("R7 reload", src_addr, 32'h6000);
        beat(1'b1, "R7 grant");
        chk("R7 progress cleared", {31'd0, rpt_irq}, 0);
        chk("R7 step after reload", src_addr, 32'h6010);
        beat(1'b1, "R7 grant");
        chk("R7 snap to new start", src_addr, 32'h6000);
        chk("R7 irq", {31'd0, rpt_irq}, 1);
        wr(3'd5, 32'h1);

        // R11 total count
        wr(3'd3, 32'h0);
        wr(3'd6, 32'd3);
        wr(3'd0, 32'h100);
        wr(3'd4, 32'h116);
        for (int i = 0; i < 3; i++) begin
            chk("R11 not done yet", {31'd0, done_flag}, 0);
            beat(1'b1, "R11 grant");
        end
        chk("R11 done", {31'd0, done_flag}, 1);
        beat(1'b0, "R11 stopped");
        wr(3'd4, 32'h116);
        beat(1'b0, "R11 enable ignored while done");
        chk("R11 src held", src_addr, 32'h130);
        wr(3'd5, 32'h2);
        chk("R11 done cleared", {31'd0, done_flag}, 0);

        // R12 count-zero and repeat end on same beat
        wr(3'd3, 32'h8);
        wr(3'd6, 32'd2);
        wr(3'd0, 32'h200);
        wr(3'd4, 32'h116);
        beat(1'b1, "R12 grant");
        beat(1'b1, "R12 grant");
        chk("R12 done set", {31'd0, done_flag}, 1);
        chk("R12 irq suppressed", {31'd0, rpt_irq}, 0);
        chk("R12 src snapped", src_addr, 32'h200);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule